// File: doc/BRIEF.md
# Cascaded Shift-Latch Chain Loader

This block drives a string of daisy-chained serial-in, parallel-out registers that each have their own output latch. A host presents a frame of `NUM_DEV` × 8 bits together with a one-cycle start strobe. The controller then sends the frame out one bit per shift-clock pulse, most significant bit first, so the first bit sent ends up at the far end of the chain. When every bit of every device has been shifted, it gives the storage clock a single pulse, so that all parallel outputs of the chain change together. It then raises a one-cycle done flag.

The widths of the shift-clock high and low phases are set at run time, in system clocks, through two input fields. The serial line changes only when the shift clock falls. It therefore stays stable for at least one system clock on each side of every rising edge. An output-blanking input is passed to the chain's active-low enable line. This path is separate from loading, so the outputs can be blanked or shown at any moment.

Top module: `shift_chain_loader`

## Requirements
- R1: `lclk_o` is low from the accepted start until the last shift pulse has ended, and is never high in the same cycle as `sclk_o`.
- R2: `ser_o` changes only in a cycle where `sclk_o` falls or a frame begins. It keeps its value through the whole low phase before each rising edge of `sclk_o` and through the whole high phase after it.
- R3: Each frame produces exactly `NUM_DEV`×8 rising edges on `sclk_o`. The frame is sent from bit `NUM_DEV*8-1` down to bit 0, so after the latch the chain's parallel output bit k equals frame bit k.
- R4: Each frame produces exactly one pulse on `lclk_o`, and it comes after the last shift pulse.
- R5: The chain's parallel outputs keep the previous frame until the latch pulse, and afterwards equal the `frame_i` captured with the accepted start.
- R6: `busy_o` is high from the cycle after an accepted start through the cycle in which `done_o` is high. `done_o` is high for exactly one cycle, after `lclk_o` has returned low, and `busy_o` is low in the cycle after that.
- R7: Each high phase of `sclk_o` and of `lclk_o` lasts `high_time_i` cycles. Each low phase before a shift rising edge, and the gap before the latch pulse, lasts `low_time_i` cycles. A value of 0 is treated as 1.
- R8: A start strobe received while `busy_o` is high is ignored. The frame in progress is neither reloaded nor restarted.
- R9: `oe_n_o` equals `blank_i` delayed by one clock, whether or not a frame is being loaded.
- R10: During and right after reset, `ser_o`, `sclk_o`, `lclk_o`, `busy_o` and `done_o` are low and `oe_n_o` is high (outputs blanked).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request to load a frame |
| frame_i | input | NUM_DEV*8 | Frame to send, captured with an accepted start |
| high_time_i | input | TIME_W | Pulse high time in system clocks (0 acts as 1) |
| low_time_i | input | TIME_W | Pulse low/setup time in system clocks (0 acts as 1) |
| blank_i | input | 1 | High to blank the chain outputs |
| ser_o | output | 1 | Serial data to the first device of the chain |
| sclk_o | output | 1 | Shift clock, data taken on its rising edge |
| lclk_o | output | 1 | Storage (latch) clock |
| oe_n_o | output | 1 | Active-low output enable for the chain |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle pulse when the frame has been latched |

## Verification
The bench builds the block with `NUM_DEV = 3` and `TIME_W = 4`. The 24-bit frame makes the bit order cross two device boundaries, and this is checked through a modelled three-device chain. The narrow time field keeps the phase widths 0 (clamped to 1), 1 and the maximum of 15 cheap enough to test all of them. The model makes it possible to check that the outputs hold the old frame until the latch. Start strobes and blanking changes issued in the middle of a frame exercise the ignore and independence rules.

// File: rtl/shift_chain_pkg.sv
package shift_chain_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_SETUP = 3'd1,
        ST_HIGH  = 3'd2,
        ST_GAP   = 3'd3,
        ST_LATCH = 3'd4,
        ST_TAIL  = 3'd5,
        ST_DONE  = 3'd6
    } ld_state_e;

    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } phase_sel_e;

    typedef struct packed {
        logic       tmr_load;
        phase_sel_e tmr_sel;
        logic       frm_load;
        logic       bit_step;
    } seq_ctrl_t;

    function automatic logic in_shift_phase(ld_state_e s);
        return (s == ST_SETUP) || (s == ST_HIGH);
    endfunction

endpackage

// File: rtl/shift_chain_timer.sv
module shift_chain_timer #(
    parameter int TIME_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [TIME_W-1:0] len_i,
    output logic              expired_o
);
    logic [TIME_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= (len_i == '0) ? '0 : len_i - 1'b1;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/shift_chain_serializer.sv
module shift_chain_serializer #(
    parameter int NUM_DEV = 2,
    localparam int FRAME_W = NUM_DEV * 8,
    localparam int IDX_W = (FRAME_W > 1) ? $clog2(FRAME_W) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load_i,
    input  logic [FRAME_W-1:0] frame_i,
    input  logic               step_i,
    output logic               bit_o,
    output logic               last_o
);
    logic [FRAME_W-1:0] frame_q;
    logic [IDX_W-1:0]   idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_q <= '0;
            idx_q   <= '0;
        end else if (load_i) begin
            frame_q <= frame_i;
            idx_q   <= IDX_W'(FRAME_W - 1);
        end else if (step_i) begin
            idx_q   <= idx_q - 1'b1;
        end
    end

    assign bit_o  = frame_q[idx_q];
    assign last_o = (idx_q == '0);

    // R3: the sequencer never steps past bit 0
    a_r3_no_underflow: assert property (@(posedge clk) disable iff (rst)
        step_i |-> (idx_q != '0));

endmodule

// File: rtl/shift_chain_fsm.sv
module shift_chain_fsm
    import shift_chain_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      start_i,
    input  logic      tmr_expired_i,
    input  logic      last_bit_i,
    output ld_state_e state_o,
    output seq_ctrl_t ctrl_o
);
    ld_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        ctrl_o  = '0;
        case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    state_d         = ST_SETUP;
                    ctrl_o.frm_load = 1'b1;
                    ctrl_o.tmr_load = 1'b1;
                    ctrl_o.tmr_sel  = PH_LOW;
                end
            end
            ST_SETUP: begin
                if (tmr_expired_i) begin
                    state_d         = ST_HIGH;
                    ctrl_o.tmr_load = 1'b1;
                    ctrl_o.tmr_sel  = PH_HIGH;
                end
            end
            ST_HIGH: begin
                if (tmr_expired_i) begin
                    ctrl_o.tmr_load = 1'b1;
                    ctrl_o.tmr_sel  = PH_LOW;
                    if (last_bit_i) begin
                        state_d = ST_GAP;
                    end else begin
                        state_d         = ST_SETUP;
                        ctrl_o.bit_step = 1'b1;
                    end
                end
            end
            ST_GAP: begin
                if (tmr_expired_i) begin
                    state_d         = ST_LATCH;
                    ctrl_o.tmr_load = 1'b1;
                    ctrl_o.tmr_sel  = PH_HIGH;
                end
            end
            ST_LATCH: begin
                if (tmr_expired_i) state_d = ST_TAIL;
            end
            ST_TAIL:  state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    assign state_o = state_q;

    // R8: a frame in progress is never reloaded
    a_r8_no_reload: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_IDLE) |-> !ctrl_o.frm_load);

endmodule

// File: rtl/shift_chain_loader.sv
module shift_chain_loader
    import shift_chain_pkg::*;
#(
    parameter int NUM_DEV = 2,
    parameter int TIME_W = 8,
    localparam int FRAME_W = NUM_DEV * 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start_i,
    input  logic [FRAME_W-1:0] frame_i,
    input  logic [TIME_W-1:0]  high_time_i,
    input  logic [TIME_W-1:0]  low_time_i,
    input  logic               blank_i,
    output logic               ser_o,
    output logic               sclk_o,
    output logic               lclk_o,
    output logic               oe_n_o,
    output logic               busy_o,
    output logic               done_o
);
    ld_state_e         state;
    seq_ctrl_t         ctrl;
    logic              tmr_expired;
    logic              cur_bit;
    logic              last_bit;
    logic [TIME_W-1:0] phase_len;
    logic              oe_n_q;

    assign phase_len = (ctrl.tmr_sel == PH_HIGH) ? high_time_i : low_time_i;

    shift_chain_fsm u_fsm (
        .clk           (clk),
        .rst           (rst),
        .start_i       (start_i),
        .tmr_expired_i (tmr_expired),
        .last_bit_i    (last_bit),
        .state_o       (state),
        .ctrl_o        (ctrl)
    );

    shift_chain_timer #(.TIME_W(TIME_W)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .load_i    (ctrl.tmr_load),
        .len_i     (phase_len),
        .expired_o (tmr_expired)
    );

    shift_chain_serializer #(.NUM_DEV(NUM_DEV)) u_ser (
        .clk     (clk),
        .rst     (rst),
        .load_i  (ctrl.frm_load),
        .frame_i (frame_i),
        .step_i  (ctrl.bit_step),
        .bit_o   (cur_bit),
        .last_o  (last_bit)
    );

    always_ff @(posedge clk) begin
        if (rst) oe_n_q <= 1'b1;
        else     oe_n_q <= blank_i;
    end

    assign ser_o  = in_shift_phase(state) ? cur_bit : 1'b0;
    assign sclk_o = (state == ST_HIGH);
    assign lclk_o = (state == ST_LATCH);
    assign busy_o = (state != ST_IDLE);
    assign done_o = (state == ST_DONE);
    assign oe_n_o = oe_n_q;

    // R1: storage clock never overlaps a shift pulse
    a_r1_latch_quiet: assert property (@(posedge clk) disable iff (rst)
        sclk_o |-> !lclk_o);

    // R2: serial data holds across the rising edge and the high phase
    a_r2_ser_hold: assert property (@(posedge clk) disable iff (rst)
        sclk_o |-> $stable(ser_o));

    // R4: latch pulse only follows the post-shift gap
    a_r4_latch_after_gap: assert property (@(posedge clk) disable iff (rst)
        $rose(lclk_o) |-> ($past(state) == ST_GAP));

    // R6: done is a single-cycle pulse
    a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

endmodule

// File: tb/shift_chain_loader_bench.sv
module shift_chain_loader_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NUM_DEV    = 3;
    localparam int TIME_W     = 4;
    localparam int FRAME_W    = NUM_DEV * 8;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               start = 1'b0;
    logic [FRAME_W-1:0] frame = '0;
    logic [TIME_W-1:0]  hi_t = '0;
    logic [TIME_W-1:0]  lo_t = '0;
    logic               blank = 1'b1;
    logic ser, sclk, lclk, oe_n, busy, done;

    int checks = 0;
    int errors = 0;

    shift_chain_loader #(.NUM_DEV(NUM_DEV), .TIME_W(TIME_W)) u_shift_chain_loader (
        .clk(clk), .rst(rst), .start_i(start), .frame_i(frame),
        .high_time_i(hi_t), .low_time_i(lo_t), .blank_i(blank),
        .ser_o(ser), .sclk_o(sclk), .lclk_o(lclk), .oe_n_o(oe_n),
        .busy_o(busy), .done_o(done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // chain model and scoreboard state
    logic [FRAME_W-1:0] chain_sh, chain_out, shown;
    logic [FRAME_W-1:0] exp_q[$];
    int exp_hi = 1, exp_lo = 1;
    int pulses, latches, low_run, high_run, lhigh;
    logic p_sclk, p_lclk, p_ser, p_busy, p_done, p_blank;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, expv, $time);
        end
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst) begin
            chain_sh = '0; chain_out = '0; shown = '0;
            pulses = 0; latches = 0; low_run = 0; high_run = 0; lhigh = 0;
            p_sclk = 0; p_lclk = 0; p_ser = 0; p_busy = 0; p_done = 0; p_blank = blank;
        end else begin
            chk(oe_n == p_blank, "R9 oe follows blank", 64'(oe_n), 64'(p_blank));
            if (busy && !p_busy) begin
                pulses = 0; latches = 0; low_run = 0;
            end
            if (sclk && !p_sclk) begin
                pulses++;
                chk(low_run == exp_lo, "R7 shift low time", 64'(low_run), 64'(exp_lo));
                chk(ser == p_ser, "R2 setup before rise", 64'(ser), 64'(p_ser));
                chk(latches == 0, "R1 no latch before shifting ends", 64'(latches), 64'd0);
                chain_sh = {chain_sh[FRAME_W-2:0], ser};
                high_run = 1;
            end else if (sclk) begin
                high_run++;
                chk(ser == p_ser, "R2 hold during high", 64'(ser), 64'(p_ser));
            end
            if (!sclk && p_sclk) begin
                chk(high_run == exp_hi, "R7 shift high time", 64'(high_run), 64'(exp_hi));
                low_run = 1;
            end else if (busy && !sclk && !lclk) begin
                low_run++;
            end
            if (sclk || lclk)
                chk(!(sclk && lclk), "R1 latch low during shift", 64'(lclk), 64'd0);
            if (lclk && !p_lclk) begin
                latches++;
                chk(pulses == FRAME_W, "R3 pulse count before latch", 64'(pulses), 64'(FRAME_W));
                chk(low_run == exp_lo, "R7 gap before latch", 64'(low_run), 64'(exp_lo));
                chain_out = chain_sh;
                lhigh = 1;
            end else if (lclk) begin
                lhigh++;
            end
            if (!lclk && p_lclk)
                chk(lhigh == exp_hi, "R7 latch high time", 64'(lhigh), 64'(exp_hi));
            if (busy && latches == 0)
                chk(chain_out == shown, "R5 outputs hold old frame", 64'(chain_out), 64'(shown));
            if (done) begin
                chk(!p_done, "R6 done single cycle", 64'(p_done), 64'd0);
                chk(!lclk && busy, "R6 done after latch, busy", 64'({lclk, busy}), 64'b01);
                chk(latches == 1, "R4 one latch pulse", 64'(latches), 64'd1);
                chk(pulses == FRAME_W, "R3 total pulses", 64'(pulses), 64'(FRAME_W));
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R5 unexpected frame", 64'(chain_out), 64'd0);
                end else begin
                    logic [FRAME_W-1:0] e;
                    e = exp_q.pop_front();
                    chk(chain_out == e, "R5 R3 latched frame", 64'(chain_out), 64'(e));
                    shown = e;
                end
            end
            p_sclk = sclk; p_lclk = lclk; p_ser = ser; p_busy = busy; p_done = done; p_blank = blank;
        end
    end

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic send(input logic [FRAME_W-1:0] f, input int hi, input int lo, input bit poke);
        int guard;
        step();
        hi_t = TIME_W'(hi); lo_t = TIME_W'(lo);
        exp_hi = (hi == 0) ? 1 : hi;
        exp_lo = (lo == 0) ? 1 : lo;
        exp_q.push_back(f);
        frame = f; start = 1'b1;
        step();
        start = 1'b0; frame = ~f;
        chk(busy == 1'b1, "R6 busy after start", 64'(busy), 64'd1);
        if (poke) begin
            repeat (7) step();
            start = 1'b1; blank = ~blank;   // R8 ignored start, R9 mid-frame blank
            step();
            start = 1'b0;
            repeat (3) step();
            blank = ~blank;
        end
        guard = 0;
        while (!done && guard < 5000) begin step(); guard++; end
        step();
        chk(!busy && !done, "R6 idle after done", 64'({busy, done}), 64'd0);
    endtask

    initial begin
        repeat (3) step();
        chk({ser, sclk, lclk, busy, done, oe_n} == 6'b000001, "R10 reset outputs",
            64'({ser, sclk, lclk, busy, done, oe_n}), 64'b000001);
        rst = 1'b0;
        blank = 1'b0;
        step();
        chk({ser, sclk, lclk, busy, done} == 5'b0, "R10 idle after reset",
            64'({ser, sclk, lclk, busy, done}), 64'd0);
        step();
        chk(oe_n == 1'b0, "R9 enable shown", 64'(oe_n), 64'd0);

        send(24'hA5C381, 1, 1, 1'b0);
        send(24'hFFFFFF, 2, 3, 1'b0);
        send(24'h000000, 0, 0, 1'b0);          // R7 zero acts as one
        send(24'h800001, 15, 15, 1'b0);        // R3 end bits, max widths
        send(24'h555555, 3, 1, 1'b1);          // R8 start while busy
        repeat (4) step();
        chk(!busy, "R8 no restart", 64'(busy), 64'd0);
        chk(chain_out == 24'h555555, "R8 frame kept", 64'(chain_out), 64'h555555);
        blank = 1'b1;
        step(); step();
        chk(oe_n == 1'b1, "R9 blanked", 64'(oe_n), 64'd1);
        chk(chain_out == 24'h555555, "R9 blank leaves latch", 64'(chain_out), 64'h555555);
        blank = 1'b0;
        for (int i = 0; i < 6; i++) begin
            send(FRAME_W'($urandom), 1 + (i % 4), 1 + (i % 3), (i % 2) == 1);
        end
        repeat (5) step();
        chk(exp_q.size() == 0, "R5 all frames latched", 64'(exp_q.size()), 64'd0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule